// File: doc/BRIEF.md
# Banked Multi-Lane Scratchpad

This block is a scratchpad memory organised as 32 banks, each one 32-bit word wide. Consecutive word addresses go to consecutive banks. A client issues one vector request at a time, and a request carries up to 32 lanes. Each lane has an active flag, a word address, a write flag and write data. The block then serves as many lanes as the bank structure allows in each cycle ("pass"). It keeps replaying the request until every active lane has been served.

Two lanes that name the exact same word are served together as a broadcast. Two lanes that land in one bank at different words collide, and the later one waits for a further pass. Conflicts are resolved only among the lanes of the request being handled. The order in which a lane walks addresses from one request to the next has no effect. When the last lane completes, the block presents the per-lane read data and the number of passes used on a response port. Both the request port and the response port use a valid/ready handshake.

Top module: `sp_banked_scratch`

## Requirements
- R1: Word address A lives in bank A mod 32 at row A div 32 (a 9-bit address: bits 4:0 select the bank, bits 8:5 select the row). A word written at A is returned by any later read of A.
- R2: After reset, req_ready is 1, rsp_valid is 0, and every stored word reads as zero.
- R3: rsp_passes equals the largest number of distinct word addresses that the active lanes place in any single bank, and is never less than 1.
- R4: Active lanes that all name the same word complete in a single pass (broadcast).
- R5: Active lanes with distinct addresses in distinct banks complete in one pass, in any lane-to-address order. Distinct addresses that share a bank each need their own pass.
- R6: An inactive lane returns zero read data and writes nothing.
- R7: When several active lanes in one request write the same word, the data of the highest-numbered such lane is stored.
- R8: Every active lane, writing or not, returns the word's contents from before the request. A write in a request is not visible to reads of that same request.
- R9: req_ready is 0 from the cycle after a request is accepted until the response handshake completes. While rsp_valid is 1 and rsp_ready is 0, the response data and the pass count hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_active | input | 32 | Per-lane active flag |
| req_addr | input | 288 | Per-lane 9-bit word address, lane l at bits 9l+8:9l |
| req_we | input | 32 | Per-lane write flag |
| req_wdata | input | 1024 | Per-lane write word, lane l at bits 32l+31:32l |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Client takes the response |
| rsp_rdata | output | 1024 | Per-lane read word, lane l at bits 32l+31:32l |
| rsp_passes | output | 6 | Number of passes the request used |

## Verification
Suppose the per-bank selection or the pending mask went wrong. The pass count on the very next response would then differ from the distinct-words-per-bank figure, or the request would never finish, and the bench would see either within a few dozen cycles. A bad write-data choice or a bad bank routing corrupts storage without any signal at that moment. It comes out only when a later request reads the affected words, so the bench follows every write pattern with a read pattern over the same addresses. An error in the read-data capture shows at once, in the same response, because every lane is compared against a reference memory that holds each word's contents from before the request.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int LANES     = 32;
    localparam int BANKS     = 32;
    localparam int ROWS      = 16;
    localparam int WORD_W    = 32;
    localparam int BANK_BITS = $clog2(BANKS);
    localparam int ROW_BITS  = $clog2(ROWS);
    localparam int ADDR_W    = BANK_BITS + ROW_BITS;
    localparam int PASS_W    = $clog2(LANES) + 1;

    typedef logic [ADDR_W-1:0]    addr_t;
    typedef logic [BANK_BITS-1:0] bank_t;
    typedef logic [ROW_BITS-1:0]  row_t;
    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [LANES-1:0]     lane_mask_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_RESP = 2'd2
    } state_t;

    function automatic bank_t bank_of(input addr_t a);
        return a[BANK_BITS-1:0];
    endfunction

    function automatic row_t row_of(input addr_t a);
        return a[ADDR_W-1:BANK_BITS];
    endfunction
endpackage

// File: rtl/sp_bank.sv
module sp_bank
    import sp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  row_t  row,
    input  logic  wr_en,
    input  word_t wr_data,
    output word_t rd_data
);
    word_t mem_q [ROWS];

    assign rd_data = mem_q[row];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
        end else if (wr_en) begin
            mem_q[row] <= wr_data;
        end
    end
endmodule

// File: rtl/sp_pass_arbiter.sv
module sp_pass_arbiter
    import sp_pkg::*;
(
    input  lane_mask_t pending,
    input  addr_t      lane_addr [LANES],
    input  lane_mask_t lane_we,
    input  word_t      lane_wdata [LANES],
    output lane_mask_t served,
    output row_t       bank_row [BANKS],
    output logic [BANKS-1:0] bank_wen,
    output word_t      bank_wdata [BANKS]
);
    logic [BANKS-1:0] sel_vld;

    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            sel_vld[b]    = 1'b0;
            bank_row[b]   = '0;
            bank_wen[b]   = 1'b0;
            bank_wdata[b] = '0;
        end
        // Walk downward so the lowest-numbered pending lane claims each bank.
        for (int l = LANES - 1; l >= 0; l--) begin
            if (pending[l]) begin
                sel_vld[bank_of(lane_addr[l])]  = 1'b1;
                bank_row[bank_of(lane_addr[l])] = row_of(lane_addr[l]);
            end
        end
        // Every pending lane naming the claimed word rides the same pass.
        for (int l = 0; l < LANES; l++) begin
            served[l] = pending[l] && sel_vld[bank_of(lane_addr[l])]
                        && (row_of(lane_addr[l]) == bank_row[bank_of(lane_addr[l])]);
        end
        // Walk upward so the highest-numbered served writer wins the bank.
        for (int l = 0; l < LANES; l++) begin
            if (served[l] && lane_we[l]) begin
                bank_wen[bank_of(lane_addr[l])]   = 1'b1;
                bank_wdata[bank_of(lane_addr[l])] = lane_wdata[l];
            end
        end
    end
endmodule

// File: rtl/sp_banked_scratch.sv
module sp_banked_scratch
    import sp_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [LANES-1:0]          req_active,
    input  logic [LANES*ADDR_W-1:0]   req_addr,
    input  logic [LANES-1:0]          req_we,
    input  logic [LANES*WORD_W-1:0]   req_wdata,
    output logic                      rsp_valid,
    input  logic                      rsp_ready,
    output logic [LANES*WORD_W-1:0]   rsp_rdata,
    output logic [PASS_W-1:0]         rsp_passes
);
    state_t           st_q;
    addr_t            addr_q [LANES];
    word_t            wd_q   [LANES];
    word_t            rd_q   [LANES];
    lane_mask_t       act_q, we_q, pend_q, served, arb_pending;
    logic [PASS_W-1:0] pass_q;

    row_t             bank_row   [BANKS];
    logic [BANKS-1:0] bank_wen;
    word_t            bank_wdata [BANKS];
    word_t            bank_rd    [BANKS];

    assign req_ready  = (st_q == ST_IDLE);
    assign rsp_valid  = (st_q == ST_RESP);
    assign rsp_passes = pass_q;
    assign arb_pending = (st_q == ST_BUSY) ? pend_q : '0;

    for (genvar l = 0; l < LANES; l++) begin : g_out
        assign rsp_rdata[l*WORD_W +: WORD_W] = rd_q[l];
    end

    sp_pass_arbiter u_arb (
        .pending    (arb_pending),
        .lane_addr  (addr_q),
        .lane_we    (we_q),
        .lane_wdata (wd_q),
        .served     (served),
        .bank_row   (bank_row),
        .bank_wen   (bank_wen),
        .bank_wdata (bank_wdata)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sp_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .row     (bank_row[b]),
            .wr_en   (bank_wen[b]),
            .wr_data (bank_wdata[b]),
            .rd_data (bank_rd[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            act_q  <= '0;
            we_q   <= '0;
            pend_q <= '0;
            pass_q <= '0;
            for (int l = 0; l < LANES; l++) begin
                addr_q[l] <= '0;
                wd_q[l]   <= '0;
                rd_q[l]   <= '0;
            end
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    st_q   <= ST_BUSY;
                    act_q  <= req_active;
                    we_q   <= req_we;
                    pend_q <= req_active;
                    pass_q <= '0;
                    for (int l = 0; l < LANES; l++) begin
                        addr_q[l] <= req_addr[l*ADDR_W +: ADDR_W];
                        wd_q[l]   <= req_wdata[l*WORD_W +: WORD_W];
                        rd_q[l]   <= '0;
                    end
                end
                ST_BUSY: begin
                    pend_q <= pend_q & ~served;
                    pass_q <= pass_q + 1'b1;
                    for (int l = 0; l < LANES; l++) begin
                        if (served[l]) rd_q[l] <= bank_rd[bank_of(addr_q[l])];
                    end
                    if ((pend_q & ~served) == '0) st_q <= ST_RESP;
                end
                ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R9
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_passes)));

    // R3
    pass_range_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_passes >= 1 && rsp_passes <= LANES));

    // R5
    busy_progress_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BUSY && pend_q != '0) |-> (served != '0));

    for (genvar l = 0; l < LANES; l++) begin : g_idle_chk
        // R6
        idle_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (rsp_valid && !act_q[l]) |-> (rsp_rdata[l*WORD_W +: WORD_W] == '0));
    end
endmodule

// File: tb/sp_banked_scratch_bench.sv
module sp_banked_scratch_bench;
    import sp_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, rsp_ready = 1'b1;
    logic req_ready, rsp_valid;
    logic [LANES-1:0] req_active = '0, req_we = '0;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic [LANES*WORD_W-1:0] req_wdata = '0;
    logic [LANES*WORD_W-1:0] rsp_rdata;
    logic [PASS_W-1:0] rsp_passes;

    always #5 clk = ~clk;

    sp_banked_scratch u_sp_banked_scratch (.*);

    int tests = 0, fails = 0;
    word_t model [BANKS*ROWS];
    addr_t a_addr [LANES];
    word_t a_wd [LANES];
    lane_mask_t a_act, a_we;

    typedef struct packed {
        logic [8:0]  base;
        logic [8:0]  stride;
        logic [31:0] act;
        logic [31:0] we;
        logic [5:0]  passes;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{9'd0,   9'd1,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd1,  8'h11}, // R1 fill
        '{9'd0,   9'd1,  32'hFFFF_FFFF, 32'h0,         6'd1,  8'h00}, // R1 read
        '{9'd5,   9'd0,  32'hFFFF_FFFF, 32'h0,         6'd1,  8'h00}, // R4
        '{9'd0,   9'd2,  32'hFFFF_FFFF, 32'h0,         6'd2,  8'h00}, // R5
        '{9'd0,   9'd32, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd16, 8'h22}, // R7
        '{9'd0,   9'd32, 32'hFFFF_FFFF, 32'h0,         6'd16, 8'h00}, // R7 read
        '{9'd0,   9'd16, 32'hFFFF_FFFF, 32'h0,         6'd16, 8'h00}, // R3
        '{9'd0,   9'd64, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd8,  8'h33}, // R3 R7
        '{9'd3,   9'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd1,  8'h44}, // R5 reversed
        '{9'd3,   9'd31, 32'hFFFF_FFFF, 32'h0,         6'd1,  8'h00}, // R5 read
        '{9'd0,   9'd1,  32'h0,         32'hFFFF_FFFF, 6'd1,  8'h55}, // R3 R6 none
        '{9'd0,   9'd32, 32'h0000_00FF, 32'hFFFF_FFFF, 6'd8,  8'h66}, // R6 partial
        '{9'd0,   9'd32, 32'hFFFF_FFFF, 32'h0,         6'd16, 8'h00}, // R6 read
        '{9'd7,   9'd17, 32'hFFFF_FFFF, 32'h0,         6'd1,  8'h00}  // R5
    };

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue the lane arrays as one request, check passes and data, update model.
    task automatic run_req(input int exp_passes, input string tag, input int hold);
        word_t expd [LANES];
        int waited = 0;
        for (int l = 0; l < LANES; l++)
            expd[l] = a_act[l] ? model[a_addr[l]] : '0;
        @(negedge clk);
        req_active = a_act; req_we = a_we;
        for (int l = 0; l < LANES; l++) begin
            req_addr[l*ADDR_W +: ADDR_W]   = a_addr[l];
            req_wdata[l*WORD_W +: WORD_W]  = a_wd[l];
        end
        req_valid = 1'b1;
        rsp_ready = (hold == 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R9 ready low"}, req_ready, 0);
        while (!rsp_valid && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        chk(rsp_valid == 1'b1, {tag, " watchdog"}, rsp_valid, 1);
        if (hold != 0) begin
            logic [LANES*WORD_W-1:0] snap;
            snap = rsp_rdata;
            repeat (hold) @(negedge clk);
            chk(rsp_valid && !req_ready && rsp_rdata == snap, {tag, " R9 hold"},
                {rsp_valid, req_ready}, 2'b10);
            rsp_ready = 1'b1;
        end
        chk(rsp_passes == exp_passes, {tag, " R3 passes"}, rsp_passes, exp_passes);
        for (int l = 0; l < LANES; l++)
            chk(rsp_rdata[l*WORD_W +: WORD_W] == expd[l], $sformatf("%s R8 lane %0d", tag, l),
                rsp_rdata[l*WORD_W +: WORD_W], expd[l]);
        for (int l = 0; l < LANES; l++)
            if (a_act[l] && a_we[l]) model[a_addr[l]] = a_wd[l];
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R9 ready back"}, req_ready, 1);
    endtask

    initial begin
        for (int i = 0; i < BANKS*ROWS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R2 reset", {req_ready, rsp_valid}, 2'b10);
        a_act = '1; a_we = '0;
        for (int l = 0; l < LANES; l++) begin
            a_addr[l] = addr_t'(l * 16 + 1);
            a_wd[l] = '0;
        end
        run_req(16, "R2 zero read", 0);

        for (int v = 0; v < NV; v++) begin
            a_act = VECS[v].act; a_we = VECS[v].we;
            for (int l = 0; l < LANES; l++) begin
                a_addr[l] = addr_t'(VECS[v].base + l * VECS[v].stride);
                a_wd[l] = {VECS[v].seed, 8'(v), 8'hA5, 8'(l)};
            end
            run_req(VECS[v].passes, $sformatf("vec%0d", v), 0);
        end

        // R3 mixed: three distinct words in bank 0, one repeated
        a_act = 32'h0000_000F; a_we = '0;
        a_addr[0] = 9'd0; a_addr[1] = 9'd32; a_addr[2] = 9'd0; a_addr[3] = 9'd64;
        run_req(3, "R3 mixed", 0);

        // R8 reader and writer on one word share a pass; reader sees old value
        a_act = 32'h0000_0003; a_we = 32'h0000_0002;
        a_addr[0] = 9'd100; a_addr[1] = 9'd100; a_wd[1] = 32'hCAFE_0001;
        run_req(1, "R8 same pass", 0);
        a_we = '0;
        run_req(1, "R8 readback", 0);

        // R7 three writers on one word: highest lane stored
        a_act = 32'h8000_0101; a_we = 32'h8000_0101;
        a_addr[0] = 9'd200; a_addr[8] = 9'd200; a_addr[31] = 9'd200;
        a_wd[0] = 32'h1; a_wd[8] = 32'h2; a_wd[31] = 32'h3;
        run_req(1, "R7 triple", 0);
        a_we = '0;
        run_req(1, "R7 readback", 0);

        // R9 backpressure on the response
        a_act = '1; a_we = '0;
        for (int l = 0; l < LANES; l++) a_addr[l] = addr_t'(l);
        run_req(1, "R9 backpressure", 4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule